// File: doc/BRIEF.md
# Serial Receive Buffer with Overrun Protection

This block sits between the receive shift stage of a UART-style serial port and the processor that reads received characters. The shift stage reports each finished character with a completion strobe. The strobe comes with up to nine data bits, a framing-error flag and a parity-error flag. The shift stage also pulses a strobe when it sees the start bit of the next character. The block queues finished characters in a two-slot circular FIFO. Every slot keeps its own error flags, ninth bit and overrun marker next to the data, so status always describes the character it arrived with.

Software reads the status outputs and the ninth bit of the oldest character first. It then pulses the pop input, which retires that character together with its status. When both slots are occupied, a newly finished character is not lost. It waits in a hold stage, which stands for the shift register, until a slot frees or until the next start bit would overwrite it. Characters are lost only in that last case, and the loss is reported on the next character that enters the FIFO.

Top module: `rx_buffer_top`

## Requirements
- R1: After reset, `rx_avail_o` is 0 and all head outputs (`rd_data_o`, `rd_bit8_o`, `rd_ferr_o`, `rd_perr_o`, `rd_ovr_o`) are 0. They also read 0 whenever the FIFO is empty.
- R2: Characters are presented at the head in the order their completion strobes arrived. The FIFO never holds more than two entries.
- R3: Each entry keeps its own flags. `frame_data_i[7:0]` appears on `rd_data_o`, `frame_data_i[8]` on `rd_bit8_o`, `frame_ferr_i` on `rd_ferr_o` and `frame_perr_i` on `rd_perr_o`. While no pop occurs, the head outputs do not change.
- R4: A one-cycle pop on a non-empty FIFO removes exactly the head entry. A pop while the FIFO is empty has no effect.
- R5: A character completed while both slots are full is kept in the hold stage. On the clock after a slot frees, it moves into the FIFO, and it is later read in order.
- R6: A start strobe discards the held character only if the FIFO is full and the hold stage is occupied in that cycle. A start strobe in any other cycle loses nothing.
- R7: After a loss, the next character written into the FIFO has `rd_ovr_o` = 1. Characters written after that one have `rd_ovr_o` = 0 until another loss occurs.
- R8: `rx_avail_o` is 1 exactly when the FIFO holds at least one unread entry. It rises on the clock edge that samples a completion strobe into an empty FIFO.
- R9: While `rx_en_i` is 0, both slots, the hold stage and any pending overrun are cleared, and strobes and pops are ignored.
- R10: A completion strobe that arrives while the FIFO is full and the hold stage is occupied replaces the held character, and this counts as a loss for R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; low flushes all storage |
| start_det_i | input | 1 | One-cycle strobe: start bit of a new character seen |
| frame_done_i | input | 1 | One-cycle strobe: character complete |
| frame_data_i | input | DATA_W (9) | Character bits; bit 8 is the ninth bit |
| frame_ferr_i | input | 1 | Framing error of the completed character |
| frame_perr_i | input | 1 | Parity error of the completed character |
| rd_pop_i | input | 1 | One-cycle strobe: retire the head entry |
| rx_avail_o | output | 1 | FIFO holds at least one unread entry |
| rd_data_o | output | DATA_W-1 (8) | Low data bits of the head entry |
| rd_bit8_o | output | 1 | Ninth bit of the head entry |
| rd_ferr_o | output | 1 | Framing error of the head entry |
| rd_perr_o | output | 1 | Parity error of the head entry |
| rd_ovr_o | output | 1 | Characters were lost before the head entry |

## Verification
On every cycle, the assertions check four things. The occupancy never exceeds two. Head outputs hold still unless a pop or a flush occurs. The held character stays put while the FIFO is full and no start or completion strobe arrives. It moves out as soon as a slot is free, and it is gone after a start strobe in an overrun cycle. They also check that disabling clears the available flag and that a pop on an empty FIFO changes nothing. Only the bench scenarios can show the end-to-end results. These are the order of three queued characters, which character the overrun mark lands on and that it clears afterwards, the replacement of a held character by an early completion strobe, and that a disable also discards a pending overrun.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef struct packed {
    logic ferr;
    logic perr;
    logic ovr;
  } rxb_flags_t;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo
  import rxb_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  rxb_flags_t        push_flags_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output rxb_flags_t        head_flags_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

  logic [DATA_W-1:0] data_q  [DEPTH];
  rxb_flags_t        flags_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CMAX);
  assign count_o = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        flags_q[g] <= '0;
      end else if (flush_i) begin
        data_q[g]  <= '0;
        flags_q[g] <= '0;
      end else if (do_push && wr_ptr_q == PTR_W'(g)) begin
        data_q[g]  <= push_data_i;
        flags_q[g] <= push_flags_i;
      end
    end
  end

  // empty FIFO presents all zeros
  assign head_data_o  = empty_o ? '0 : data_q[rd_ptr_q];
  assign head_flags_o = empty_o ? '0 : flags_q[rd_ptr_q];
endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
  import rxb_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  rxb_flags_t        load_flags_i,
  input  logic              drain_i,
  input  logic              drop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output rxb_flags_t        flags_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  rxb_flags_t        flags_q;

  // load beats drain: a same-cycle move-out and refill keeps the stage busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= load_data_i;
      flags_q <= load_flags_i;
    end else if (drain_i || drop_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic start_det_i,
  input  logic frame_done_i,
  input  logic pop_req_i,
  input  logic fifo_full_i,
  input  logic fifo_empty_i,
  input  logic hold_valid_i,
  output logic flush_o,
  output logic push_o,
  output logic push_from_hold_o,
  output logic hold_load_o,
  output logic hold_drain_o,
  output logic hold_drop_o,
  output logic pop_o,
  output logic ovr_mark_o
);
  logic move, direct, overwrite, drop, loss;
  logic ovr_pend_q;

  assign flush_o   = !rx_en_i;
  assign move      = rx_en_i && hold_valid_i && !fifo_full_i;
  assign direct    = rx_en_i && frame_done_i && !hold_valid_i && !fifo_full_i;
  assign overwrite = rx_en_i && frame_done_i && hold_valid_i && fifo_full_i;
  assign drop      = rx_en_i && start_det_i && hold_valid_i && fifo_full_i && !frame_done_i;
  assign loss      = overwrite || drop;

  assign push_o           = move || direct;
  assign push_from_hold_o = move;
  assign hold_load_o      = rx_en_i && frame_done_i && !direct;
  assign hold_drain_o     = move;
  assign hold_drop_o      = drop;
  assign pop_o            = rx_en_i && pop_req_i && !fifo_empty_i;
  assign ovr_mark_o       = ovr_pend_q;

  // loss needs a full FIFO, push needs a free slot: never both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_pend_q <= 1'b0;
    else if (!rx_en_i) ovr_pend_q <= 1'b0;
    else if (loss)     ovr_pend_q <= 1'b1;
    else if (push_o)   ovr_pend_q <= 1'b0;
  end
endmodule

// File: rtl/rx_buffer_top.sv
module rx_buffer_top
  import rxb_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              start_det_i,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              frame_ferr_i,
  input  logic              frame_perr_i,
  input  logic              rd_pop_i,
  output logic              rx_avail_o,
  output logic [DATA_W-2:0] rd_data_o,
  output logic              rd_bit8_o,
  output logic              rd_ferr_o,
  output logic              rd_perr_o,
  output logic              rd_ovr_o
);
  logic              flush, push, push_from_hold, hold_load, hold_drain, hold_drop;
  logic              pop, ovr_mark;
  logic              fifo_full, fifo_empty, hold_valid;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [DATA_W-1:0] hold_data, push_data, head_data;
  rxb_flags_t        hold_flags, in_flags, push_flags, head_flags;

  assign in_flags = '{ferr: frame_ferr_i, perr: frame_perr_i, ovr: 1'b0};

  rxb_ctrl u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .rx_en_i          (rx_en_i),
    .start_det_i      (start_det_i),
    .frame_done_i     (frame_done_i),
    .pop_req_i        (rd_pop_i),
    .fifo_full_i      (fifo_full),
    .fifo_empty_i     (fifo_empty),
    .hold_valid_i     (hold_valid),
    .flush_o          (flush),
    .push_o           (push),
    .push_from_hold_o (push_from_hold),
    .hold_load_o      (hold_load),
    .hold_drain_o     (hold_drain),
    .hold_drop_o      (hold_drop),
    .pop_o            (pop),
    .ovr_mark_o       (ovr_mark)
  );

  rxb_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .load_i       (hold_load),
    .load_data_i  (frame_data_i),
    .load_flags_i (in_flags),
    .drain_i      (hold_drain),
    .drop_i       (hold_drop),
    .valid_o      (hold_valid),
    .data_o       (hold_data),
    .flags_o      (hold_flags)
  );

  always_comb begin
    push_data  = push_from_hold ? hold_data : frame_data_i;
    push_flags = push_from_hold ? hold_flags : in_flags;
    push_flags.ovr = ovr_mark;
  end

  rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .push_i       (push),
    .push_data_i  (push_data),
    .push_flags_i (push_flags),
    .pop_i        (pop),
    .head_data_o  (head_data),
    .head_flags_o (head_flags),
    .empty_o      (fifo_empty),
    .full_o       (fifo_full),
    .count_o      (fifo_cnt)
  );

  assign rx_avail_o = !fifo_empty;
  assign rd_data_o  = head_data[DATA_W-2:0];
  assign rd_bit8_o  = head_data[DATA_W-1];
  assign rd_ferr_o  = head_flags.ferr;
  assign rd_perr_o  = head_flags.perr;
  assign rd_ovr_o   = head_flags.ovr;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              start_det_i,
  input logic              frame_done_i,
  input logic              rd_pop_i,
  input logic              rx_avail_o,
  input logic [DATA_W-2:0] rd_data_o,
  input logic              rd_bit8_o,
  input logic              rd_ferr_o,
  input logic              rd_perr_o,
  input logic              rd_ovr_o,
  input logic              hold_valid,
  input logic              fifo_full,
  input logic [CNT_W-1:0]  fifo_cnt
);
  logic [DATA_W+2:0] head_all;
  assign head_all = {rd_data_o, rd_bit8_o, rd_ferr_o, rd_perr_o, rd_ovr_o};

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH));

  assert_head_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_avail_o && !rd_pop_i && rx_en_i) |=> $stable(head_all));

  assert_empty_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_avail_o && rd_pop_i && !frame_done_i) |=> !rx_avail_o);

  assert_hold_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && hold_valid && fifo_full && !rd_pop_i && !start_det_i && !frame_done_i)
      |=> hold_valid);

  assert_hold_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && hold_valid && !fifo_full && !frame_done_i) |=> !hold_valid);

  assert_start_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && start_det_i && hold_valid && fifo_full && !frame_done_i) |=> !hold_valid);

  assert_avail_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && frame_done_i && !rx_avail_o) |=> rx_avail_o);

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!rx_avail_o && !hold_valid));
endmodule

bind rx_buffer_top rxb_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_en_i      (rx_en_i),
  .start_det_i  (start_det_i),
  .frame_done_i (frame_done_i),
  .rd_pop_i     (rd_pop_i),
  .rx_avail_o   (rx_avail_o),
  .rd_data_o    (rd_data_o),
  .rd_bit8_o    (rd_bit8_o),
  .rd_ferr_o    (rd_ferr_o),
  .rd_perr_o    (rd_perr_o),
  .rd_ovr_o     (rd_ovr_o),
  .hold_valid   (hold_valid),
  .fifo_full    (fifo_full),
  .fifo_cnt     (fifo_cnt)
);

// File: tb/rx_buffer_top_test.sv
`timescale 1ns/1ps
module rx_buffer_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       start_det = 1'b0;
  logic       frame_done = 1'b0;
  logic [8:0] frame_data = '0;
  logic       frame_ferr = 1'b0;
  logic       frame_perr = 1'b0;
  logic       rd_pop = 1'b0;
  logic       rx_avail;
  logic [7:0] rd_data;
  logic       rd_bit8, rd_ferr, rd_perr, rd_ovr;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rx_buffer_top uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .start_det_i(start_det),
    .frame_done_i(frame_done), .frame_data_i(frame_data), .frame_ferr_i(frame_ferr),
    .frame_perr_i(frame_perr), .rd_pop_i(rd_pop), .rx_avail_o(rx_avail),
    .rd_data_o(rd_data), .rd_bit8_o(rd_bit8), .rd_ferr_o(rd_ferr),
    .rd_perr_o(rd_perr), .rd_ovr_o(rd_ovr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_only();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
  endtask

  task automatic done_only(input logic [8:0] d, input logic fe, input logic pe);
    @(negedge clk);
    frame_done = 1'b1; frame_data = d; frame_ferr = fe; frame_perr = pe;
    @(negedge clk);
    frame_done = 1'b0; frame_data = '0; frame_ferr = 1'b0; frame_perr = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input logic fe, input logic pe);
    start_only();
    done_only(d, fe, pe);
  endtask

  // check head, then pop it
  task automatic read_expect(input string req, input logic [8:0] d, input logic fe,
                             input logic pe, input logic ov);
    check(req, "avail", rx_avail, 1);
    check(req, "data", rd_data, d[7:0]);
    check(req, "bit8", rd_bit8, d[8]);
    check(req, "ferr", rd_ferr, fe);
    check(req, "perr", rd_perr, pe);
    check(req, "ovr", rd_ovr, ov);
    rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    check(req, "avail", rx_avail, 0);
    check(req, "head", {rd_data, rd_bit8, rd_ferr, rd_perr, rd_ovr}, 0);
  endtask

  task automatic t_reset_R1();
    expect_empty("R1");
  endtask

  task automatic t_single_R8();
    send(9'h0A5, 1'b0, 1'b0);
    check("R8", "avail after one frame", rx_avail, 1);
    read_expect("R8", 9'h0A5, 1'b0, 1'b0, 1'b0);
    expect_empty("R8");
  endtask

  task automatic t_order_flags_R3();
    send(9'h13C, 1'b1, 1'b0);
    send(9'h042, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    read_expect("R3", 9'h13C, 1'b1, 1'b0, 1'b0);  // R2 order
    read_expect("R3", 9'h042, 1'b0, 1'b1, 1'b0);
    expect_empty("R3");
  endtask

  task automatic t_empty_pop_R4();
    rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
    expect_empty("R4");
    send(9'h077, 1'b0, 1'b0);
    read_expect("R4", 9'h077, 1'b0, 1'b0, 1'b0);
    expect_empty("R4");
  endtask

  task automatic t_third_level_R5();
    send(9'h101, 1'b0, 1'b0);
    send(9'h002, 1'b1, 1'b1);
    send(9'h103, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    read_expect("R5", 9'h101, 1'b0, 1'b0, 1'b0);
    read_expect("R5", 9'h002, 1'b1, 1'b1, 1'b0);
    read_expect("R5", 9'h103, 1'b0, 1'b1, 1'b0);
    expect_empty("R5");
  endtask

  task automatic t_overrun_R7();
    send(9'h011, 1'b0, 1'b0);
    send(9'h022, 1'b0, 1'b0);
    send(9'h033, 1'b0, 1'b0);   // held
    start_only();                // R6: drops 0x33
    done_only(9'h144, 1'b1, 1'b0);
    read_expect("R7", 9'h011, 1'b0, 1'b0, 1'b0);
    read_expect("R7", 9'h022, 1'b0, 1'b0, 1'b0);
    read_expect("R6", 9'h144, 1'b1, 1'b0, 1'b1);
    expect_empty("R6");
    send(9'h055, 1'b0, 1'b0);
    read_expect("R7", 9'h055, 1'b0, 1'b0, 1'b0);  // mark cleared
  endtask

  task automatic t_no_loss_R6();
    send(9'h061, 1'b0, 1'b0);
    send(9'h062, 1'b0, 1'b0);
    start_only();                // hold empty: nothing lost
    done_only(9'h063, 1'b0, 1'b0);
    read_expect("R6", 9'h061, 1'b0, 1'b0, 1'b0);
    read_expect("R6", 9'h062, 1'b0, 1'b0, 1'b0);
    read_expect("R6", 9'h063, 1'b0, 1'b0, 1'b0);
    expect_empty("R6");
  endtask

  task automatic t_replace_R10();
    send(9'h071, 1'b0, 1'b0);
    send(9'h072, 1'b0, 1'b0);
    send(9'h073, 1'b0, 1'b0);
    done_only(9'h174, 1'b0, 1'b1);  // no start strobe: replaces 0x73
    read_expect("R10", 9'h071, 1'b0, 1'b0, 1'b0);
    read_expect("R10", 9'h072, 1'b0, 1'b0, 1'b0);
    read_expect("R10", 9'h174, 1'b0, 1'b1, 1'b1);
    expect_empty("R10");
  endtask

  task automatic t_flush_R9();
    send(9'h081, 1'b0, 1'b0);
    send(9'h082, 1'b0, 1'b0);
    send(9'h083, 1'b0, 1'b0);
    start_only();                // loss pending
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk);
    expect_empty("R9");
    send(9'h0EE, 1'b1, 1'b1);   // ignored while disabled
    expect_empty("R9");
    @(negedge clk) rx_en = 1'b1;
    @(negedge clk);
    expect_empty("R9");
    send(9'h090, 1'b0, 1'b0);
    read_expect("R9", 9'h090, 1'b0, 1'b0, 1'b0);  // pending mark discarded
    expect_empty("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    rx_en = 1'b1;
    @(negedge clk);
    t_single_R8();
    t_order_flags_R3();
    t_empty_pop_R4();
    t_third_level_R5();
    t_overrun_R7();
    t_no_loss_R6();
    t_replace_R10();
    t_flush_R9();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule